// File: doc/BRIEF.md
# Limited-Range Pixel Clamp

This block limits every colour channel of a pixel stream to a studio (limited) range. Each channel is 12 bits wide. A 3-bit format code picks the range. Three codes give fixed ranges for 8, 10 and 12 bits per channel. One code uses lower and upper bounds that are programmed per channel. The remaining codes apply no limit at all. An enable input overrides the format code and passes pixels through untouched. The block does not scale values; it only limits them.

Pixels arrive with a valid flag. The mode inputs are sampled on the same clock edge as the pixel, so the mode can change from one pixel to the next. One register stage follows the clamp logic, and the valid flag is delayed by the same stage.

A fixed range is placed at the top of the 12-bit word. Its ceiling also covers the low-order bits that a later reduction to the narrower depth would drop. After such a truncation, the top code of the range is exactly the studio white level.

The programmable bounds are held in registers inside the block. Reset loads them with their defaults. A load strobe replaces them.

Top module: `pix_range_clamp`

## Requirements
- R1: While reset is asserted, and after it, until the first valid pixel, `out_valid` is 0 and `out_pix` is all zeros.
- R2: `out_valid` equals `in_valid` of the previous clock cycle, so the latency is exactly one cycle.
- R3: When `clamp_en` is 0, the output pixel equals the input pixel for every format code.
- R4: With `clamp_en` high, format code 0 (6 bpc) and codes 4, 5 and 6 pass every channel through unchanged.
- R5: Format code 1 (8 bpc) limits each channel to 0x100..0xEBF.
- R6: Format code 2 (10 bpc) limits each channel to 0x100..0xEB3.
- R7: Format code 3 (12 bpc) limits each channel to 0x100..0xEB0.
- R8: Format code 7 limits each channel to that channel's programmable bounds. After reset the bounds are 0x010 (lower) and 0xFEF (upper) for every channel.
- R9: When `bnd_load` is high at a clock edge, all channel bounds are captured from `bnd_lo` and `bnd_hi`. Channel i uses bits [12i+11:12i] of each bus. The new bounds apply only to pixels sampled at later edges. Each channel keeps its own bounds.
- R10: The lower bound is tested first. A value below the lower bound gives the lower bound; otherwise a value above the upper bound gives the upper bound. This holds even when the lower bound exceeds the upper bound.
- R11: While `in_valid` is 0, `out_pix` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 36 | Input pixel; channel i at bits [12i+11:12i] |
| clamp_en | input | 1 | Clamp enable; 0 means pass-through |
| fmt_code | input | 3 | Range selector: 0 and 4-6 no limit, 1 8 bpc, 2 10 bpc, 3 12 bpc, 7 programmable |
| bnd_load | input | 1 | Captures the programmable bounds |
| bnd_lo | input | 36 | Programmable lower bounds, packed per channel |
| bnd_hi | input | 36 | Programmable upper bounds, packed per channel |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 36 | Clamped pixel |

## Verification
The hardest case to reach is the edge where new bounds are loaded while a code-7 pixel is sampled at the same time. The clamp must still use the old bounds for that pixel, and the new bounds only from the next pixel on. The bench drives exactly that collision, right after a sweep that relies on the reset defaults. It then loads a lower bound above the upper bound on one channel, to show that the lower bound is tested first. Every format code, with and without the enable, is swept over all 4096 values of a channel, while the other two channels carry differently ordered values.

// File: rtl/pix_clamp_pkg.sv
package pix_clamp_pkg;
    typedef enum logic [2:0] {
        RM_PASS = 3'd0,
        RM_B8   = 3'd1,
        RM_B10  = 3'd2,
        RM_B12  = 3'd3,
        RM_PROG = 3'd4
    } rng_mode_e;
endpackage

// File: rtl/pcl_mode_dec.sv
module pcl_mode_dec
    import pix_clamp_pkg::*;
(
    input  logic       clamp_en,
    input  logic [2:0] fmt_code,
    output rng_mode_e  mode
);
    always_comb begin
        mode = RM_PASS;
        if (clamp_en) begin
            unique case (fmt_code)
                3'd1:    mode = RM_B8;
                3'd2:    mode = RM_B10;
                3'd3:    mode = RM_B12;
                3'd7:    mode = RM_PROG;
                default: mode = RM_PASS;
            endcase
        end
    end
endmodule

// File: rtl/pcl_bound_regs.sv
module pcl_bound_regs #(
    parameter int CH_W   = 12,
    parameter int NUM_CH = 3,
    parameter int DEF_LO = 'h010,
    parameter int DEF_HI = 'hFEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NUM_CH*CH_W-1:0]   lo_in,
    input  logic [NUM_CH*CH_W-1:0]   hi_in,
    output logic [NUM_CH*CH_W-1:0]   lo_q,
    output logic [NUM_CH*CH_W-1:0]   hi_q
);
    localparam logic [CH_W-1:0] LO_RST = CH_W'(DEF_LO);
    localparam logic [CH_W-1:0] HI_RST = CH_W'(DEF_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                lo_q[i*CH_W +: CH_W] <= LO_RST;
                hi_q[i*CH_W +: CH_W] <= HI_RST;
            end
        end else if (load) begin
            lo_q <= lo_in;
            hi_q <= hi_in;
        end
    end
endmodule

// File: rtl/pcl_chan_clamp.sv
module pcl_chan_clamp
    import pix_clamp_pkg::*;
#(
    parameter int CH_W = 12
) (
    input  logic [CH_W-1:0] x,
    input  rng_mode_e       mode,
    input  logic [CH_W-1:0] prog_lo,
    input  logic [CH_W-1:0] prog_hi,
    output logic [CH_W-1:0] y
);
    localparam int SH = CH_W - 8;
    localparam logic [CH_W-1:0] LO_FIX = CH_W'(16 << SH);
    localparam logic [CH_W-1:0] HI_B8  = CH_W'((235 << SH) + (1 << (CH_W - 8)) - 1);
    localparam logic [CH_W-1:0] HI_B10 = CH_W'((235 << SH) + (1 << (CH_W - 10)) - 1);
    localparam logic [CH_W-1:0] HI_B12 = CH_W'((235 << SH) + (1 << (CH_W - 12)) - 1);

    logic [CH_W-1:0] lo, hi;
    logic            limit;

    always_comb begin
        limit = 1'b1;
        lo    = LO_FIX;
        hi    = HI_B12;
        unique case (mode)
            RM_B8:   hi = HI_B8;
            RM_B10:  hi = HI_B10;
            RM_B12:  hi = HI_B12;
            RM_PROG: begin
                lo = prog_lo;
                hi = prog_hi;
            end
            default: limit = 1'b0;
        endcase
    end

    always_comb begin
        if (!limit)      y = x;
        else if (x < lo) y = lo;
        else if (x > hi) y = hi;
        else             y = x;
    end
endmodule

// File: rtl/pix_range_clamp.sv
module pix_range_clamp
    import pix_clamp_pkg::*;
#(
    parameter int CH_W   = 12,
    parameter int NUM_CH = 3,
    parameter int DEF_LO = 'h010,
    parameter int DEF_HI = 'hFEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [NUM_CH*CH_W-1:0] in_pix,
    input  logic                   clamp_en,
    input  logic [2:0]             fmt_code,
    input  logic                   bnd_load,
    input  logic [NUM_CH*CH_W-1:0] bnd_lo,
    input  logic [NUM_CH*CH_W-1:0] bnd_hi,
    output logic                   out_valid,
    output logic [NUM_CH*CH_W-1:0] out_pix
);
    localparam int PIX_W = NUM_CH * CH_W;

    rng_mode_e        mode;
    logic [PIX_W-1:0] lo_q, hi_q, clamped;

    pcl_mode_dec u_dec (
        .clamp_en (clamp_en),
        .fmt_code (fmt_code),
        .mode     (mode)
    );

    pcl_bound_regs #(
        .CH_W(CH_W), .NUM_CH(NUM_CH), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
    ) u_bnd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bnd_load),
        .lo_in (bnd_lo),
        .hi_in (bnd_hi),
        .lo_q  (lo_q),
        .hi_q  (hi_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pcl_chan_clamp #(.CH_W(CH_W)) u_clamp (
            .x       (in_pix[c*CH_W +: CH_W]),
            .mode    (mode),
            .prog_lo (lo_q[c*CH_W +: CH_W]),
            .prog_hi (hi_q[c*CH_W +: CH_W]),
            .y       (clamped[c*CH_W +: CH_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_pix <= clamped;
        end
    end
endmodule

// File: rtl/pix_range_clamp_chk.sv
module pix_range_clamp_chk #(
    parameter int CH_W   = 12,
    parameter int NUM_CH = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [NUM_CH*CH_W-1:0] in_pix,
    input logic                   clamp_en,
    input logic [2:0]             fmt_code,
    input logic                   out_valid,
    input logic [NUM_CH*CH_W-1:0] out_pix
);
    localparam int SH = CH_W - 8;
    localparam int LO_FIX = 16 << SH;
    localparam int HI_B8  = (235 << SH) + (1 << (CH_W - 8)) - 1;
    localparam int HI_B12 = (235 << SH) + (1 << (CH_W - 12)) - 1;

    function automatic logic all_in(input logic [NUM_CH*CH_W-1:0] p, input int lo, input int hi);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(p[i*CH_W +: CH_W]) < lo || int'(p[i*CH_W +: CH_W]) > hi) ok = 1'b0;
        end
        return ok;
    endfunction

    p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clamp_en) |=> out_pix == $past(in_pix));
    p_open_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_en && (fmt_code == 3'd0 || fmt_code == 3'd4 ||
         fmt_code == 3'd5 || fmt_code == 3'd6)) |=> out_pix == $past(in_pix));
    p_range8_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_en && fmt_code == 3'd1) |=> all_in(out_pix, LO_FIX, HI_B8));
    p_range12_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_en && fmt_code == 3'd3) |=> all_in(out_pix, LO_FIX, HI_B12));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pix));
endmodule

bind pix_range_clamp pix_range_clamp_chk #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .clamp_en  (clamp_en),
    .fmt_code  (fmt_code),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/pix_range_clamp_bench.sv
module pix_range_clamp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [35:0] in_pix = '0;
    logic        clamp_en = 1'b0;
    logic [2:0]  fmt_code = 3'd0;
    logic        bnd_load = 1'b0;
    logic [35:0] bnd_lo = '0;
    logic [35:0] bnd_hi = '0;
    logic        out_valid;
    logic [35:0] out_pix;

    int checks = 0;
    int errors = 0;
    int mlo [3] = '{16, 16, 16};
    int mhi [3] = '{4079, 4079, 4079};

    always #4 clk = ~clk;

    pix_range_clamp u_pix_range_clamp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .clamp_en(clamp_en), .fmt_code(fmt_code), .bnd_load(bnd_load),
        .bnd_lo(bnd_lo), .bnd_hi(bnd_hi), .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int exp_ch(int x, bit en, int code, int plo, int phi);
        int lo, hi;
        if (!en) return x;
        case (code)
            1: begin lo = 256; hi = 3775; end
            2: begin lo = 256; hi = 3763; end
            3: begin lo = 256; hi = 3760; end
            7: begin lo = plo; hi = phi; end
            default: return x;
        endcase
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic string tag_of(bit en, int code);
        if (!en) return "R3";
        case (code)
            1: return "R5";
            2: return "R6";
            3: return "R7";
            7: return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic send(logic [35:0] p, string req, logic [35:0] exp);
        @(negedge clk);
        in_valid = 1'b1;
        in_pix   = p;
        @(posedge clk);
        #1;
        check(req, out_pix, exp);
        check("R2", {35'd0, out_valid}, 36'd1);
    endtask

    function automatic logic [35:0] pack(int c0, int c1, int c2);
        return {12'(c2), 12'(c1), 12'(c0)};
    endfunction

    task automatic sweep(bit en, int code);
        int c0, c1, c2;
        clamp_en = en;
        fmt_code = 3'(code);
        for (int v = 0; v < 4096; v++) begin
            c0 = v;
            c1 = 4095 - v;
            c2 = (v * 37 + 11) % 4096;
            send(pack(c0, c1, c2), tag_of(en, code),
                 pack(exp_ch(c0, en, code, mlo[0], mhi[0]),
                      exp_ch(c1, en, code, mlo[1], mhi[1]),
                      exp_ch(c2, en, code, mlo[2], mhi[2])));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [35:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", {35'd0, out_valid}, 36'd0);
        check("R1", out_pix, 36'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", out_pix, 36'd0);

        // R3 R4 R5 R6 R7 R8 (default bounds) sweeps
        for (int e = 0; e < 2; e++) begin
            for (int code = 0; code < 8; code++) sweep(e[0], code);
        end

        // R11: output held while input is not valid; R2 valid drops
        held = out_pix;
        @(negedge clk);
        in_valid = 1'b0;
        in_pix   = pack(1, 2, 3);
        clamp_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R11", out_pix, held);
        check("R2", {35'd0, out_valid}, 36'd0);

        // R9: load on the same edge as a code-7 pixel; that pixel uses old bounds
        clamp_en = 1'b1;
        fmt_code = 3'd7;
        @(negedge clk);
        bnd_load = 1'b1;
        bnd_lo   = pack(512, 0, 2048);
        bnd_hi   = pack(768, 4095, 2047);
        in_valid = 1'b1;
        in_pix   = pack(0, 4095, 1000);
        @(posedge clk);
        #1;
        check("R9", out_pix, pack(16, 4079, 1000));
        @(negedge clk);
        bnd_load = 1'b0;
        bnd_lo   = '0;
        bnd_hi   = '0;
        mlo = '{512, 0, 2048};
        mhi = '{768, 4095, 2047};
        // R9 per-channel bounds, R10 lower bound wins on channel 2
        send(pack(0, 4095, 100), "R10", pack(512, 4095, 2048));
        send(pack(4000, 0, 4000), "R10", pack(768, 0, 2047));
        sweep(1'b1, 7);
        sweep(1'b0, 7);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        finish_run();
    end
endmodule